// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial input into parallel characters. A programmable divisor produces a sampling enable at sixteen times the bit rate. Each character is one start bit, a configurable number of data bits sent least significant first, an optional parity bit and at least one stop bit. The bits are gathered in an internal shift register that the bus cannot reach. When the first stop bit has been sampled, the whole character is copied into a receive holding register.

Status outputs report data-ready, parity error, framing error and overrun. A read strobe for the holding register clears data-ready. A separate read strobe for the line status clears the three error flags. Parity can be turned off, or set to even, odd or forced (sticky) checking.

Top module: `srx_receiver`

## Requirements
- R1: After reset, data_ready, parity_err, frame_err and overrun are 0 and rx_data is 0.
- R2: A frame with parity disabled is assembled least significant bit first. For every 8-bit value, rx_data equals the value sent and data_ready is 1 once the first stop bit has been sampled.
- R3: With cfg_parity_en=1, cfg_parity_sticky=0 and cfg_parity_even=1, the expected parity bit is the XOR of the data bits. A mismatch sets parity_err and a match leaves it 0.
- R4: With cfg_parity_en=1, cfg_parity_sticky=0 and cfg_parity_even=0, the expected parity bit is the inverse of the XOR of the data bits. A mismatch sets parity_err.
- R5: With cfg_parity_en=1 and cfg_parity_sticky=1, the expected parity bit is 0 when cfg_parity_even=1 and 1 when cfg_parity_even=0, whatever the data. A mismatch sets parity_err.
- R6: A low pulse on rx_line that is gone before the mid-start sample, which comes 8 sampling ticks after the falling edge is seen, is treated as a glitch. It sets no flag and changes nothing. The next real frame is then received correctly.
- R7: If the first stop bit is sampled low, frame_err is set and the character is still delivered to rx_data with data_ready set.
- R8: If a character completes while data_ready is still 1 and no rd_data strobe arrives in the same cycle, overrun is set and rx_data takes the new character.
- R9: A one-cycle rd_data pulse clears data_ready on the next cycle. It leaves rx_data and the error flags unchanged.
- R10: A one-cycle rd_status pulse clears parity_err, frame_err and overrun on the next cycle. It leaves data_ready unchanged.
- R11: One bit period is 16 × divisor clock cycles, for any divisor from 1 up to the maximum of the divisor width. Frames sent at divisors 1, 2, 3 and 5 are received without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input; idles high |
| divisor | input | DIV_W | Clock cycles per sampling tick (1 to max) |
| cfg_parity_en | input | 1 | A parity bit follows the data bits |
| cfg_parity_even | input | 1 | Even parity select; in sticky mode 1 means the bit is expected to be 0 |
| cfg_parity_sticky | input | 1 | Parity bit is forced to a fixed level |
| rd_data | input | 1 | Holding-register read strobe; clears data_ready |
| rd_status | input | 1 | Status read strobe; clears error flags |
| rx_data | output | DATA_W | Receive holding register |
| data_ready | output | 1 | A new character is waiting |
| parity_err | output | 1 | Sticky parity error flag |
| frame_err | output | 1 | Sticky framing error flag |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the receiver with DIV_W=8, DATA_W=8 and 16 times oversampling. An 8-bit divisor can be swept quickly, and at divisor 1 a full frame takes under 200 cycles. That makes it practical to send all 256 characters with parity off and all 256 with even parity, together with strided sweeps in odd and both sticky modes. The expected parity bit is computed from a population count. Dedicated frames cover the corner cases: a bad parity bit, a low stop bit, back-to-back characters with no read in between, a short start glitch and the larger divisors.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_state_e;

   typedef struct packed {
      logic par_en;
      logic par_even;
      logic par_sticky;
   } frame_cfg_t;

   // Level the parity bit must have, given the XOR of the data bits
   function automatic logic expected_parity(input logic data_xor, input frame_cfg_t cfg);
      if (cfg.par_sticky)
         return ~cfg.par_even;
      else if (cfg.par_even)
         return data_xor;
      else
         return ~data_xor;
   endfunction

endpackage

// File: rtl/srx_baud_gen.sv
module srx_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   // A zero divisor is outside the legal range and is run as one
   assign last = (divisor == '0) ? '0 : divisor - ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= last) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + ONE;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain <= '1;
            else if (STAGES == 1)
               chain <= {STAGES{d}};
            else
               chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  frame_cfg_t        cfg,
   output logic              done,
   output logic [DATA_W-1:0] char_q,
   output logic              par_bad,
   output logic              stop_bad
);
   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);
   localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;

   assign char_q = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bitn     <= '0;
         shreg    <= '0;
         par_acc  <= 1'b0;
         done     <= 1'b0;
         par_bad  <= 1'b0;
         stop_bad <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt     <= '0;
                     bitn    <= '0;
                     par_acc <= 1'b0;
                     par_bad <= 1'b0;
                     state   <= rx ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == FULL) begin
                     cnt     <= '0;
                     par_acc <= par_acc ^ rx;
                     if (DATA_W > 1)
                        shreg <= {rx, shreg[DATA_W-1:1]};
                     else
                        shreg <= DATA_W'(rx);
                     if (bitn == LAST)
                        state <= cfg.par_en ? RX_PARITY : RX_STOP;
                     else
                        bitn <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PARITY: begin
                  if (cnt == FULL) begin
                     cnt     <= '0;
                     par_bad <= (rx != expected_parity(par_acc, cfg));
                     state   <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == FULL) begin
                     cnt      <= '0;
                     done     <= 1'b1;
                     stop_bad <= ~rx;
                     state    <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] char_in,
   input  logic              par_bad,
   input  logic              stop_bad,
   input  logic              rd_data,
   input  logic              rd_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              data_ready,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun
);
   // Reads clear first; a completing character then sets on top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         data_ready <= 1'b0;
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
         overrun    <= 1'b0;
      end else begin
         if (done) begin
            rx_data    <= char_in;
            data_ready <= 1'b1;
            parity_err <= (parity_err & ~rd_status) | par_bad;
            frame_err  <= (frame_err & ~rd_status) | stop_bad;
            overrun    <= (overrun & ~rd_status) | (data_ready & ~rd_data);
         end else begin
            if (rd_data)
               data_ready <= 1'b0;
            if (rd_status) begin
               parity_err <= 1'b0;
               frame_err  <= 1'b0;
               overrun    <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              cfg_parity_en,
   input  logic              cfg_parity_even,
   input  logic              cfg_parity_sticky,
   input  logic              rd_data,
   input  logic              rd_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              data_ready,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun
);
   generate
      if (DATA_W < 5 || DATA_W > 8) begin : g_bad_data_w
         $error("srx_receiver: DATA_W must be 5..8");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("srx_receiver: OVS must be a power of two of at least 4");
      end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div_w
         $error("srx_receiver: DIV_W must be 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("srx_receiver: SYNC_STAGES must be 0..4");
      end
   endgenerate

   frame_cfg_t        cfg;
   logic              tick;
   logic              rx_s;
   logic              done_w;
   logic [DATA_W-1:0] char_w;
   logic              par_bad_w;
   logic              stop_bad_w;

   assign cfg = '{par_en: cfg_parity_en, par_even: cfg_parity_even,
                  par_sticky: cfg_parity_sticky};

   srx_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rx_s)
   );

   srx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rx       (rx_s),
      .cfg      (cfg),
      .done     (done_w),
      .char_q   (char_w),
      .par_bad  (par_bad_w),
      .stop_bad (stop_bad_w)
   );

   srx_holding #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done_w),
      .char_in    (char_w),
      .par_bad    (par_bad_w),
      .stop_bad   (stop_bad_w),
      .rd_data    (rd_data),
      .rd_status  (rd_status),
      .rx_data    (rx_data),
      .data_ready (data_ready),
      .parity_err (parity_err),
      .frame_err  (frame_err),
      .overrun    (overrun)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_done,
   input logic              char_par_bad,
   input logic              char_stop_bad,
   input logic              rd_data,
   input logic              rd_status,
   input logic [DATA_W-1:0] rx_data,
   input logic              data_ready,
   input logic              parity_err,
   input logic              frame_err,
   input logic              overrun
);
   AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |=> data_ready); // R2

   AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && char_par_bad) |=> parity_err); // R3

   AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && char_stop_bad) |=> frame_err); // R7

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && data_ready && !rd_data) |=> overrun); // R8

   AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !char_done) |=> !data_ready); // R9

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !char_done |=> $stable(rx_data)); // R9

   AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !char_done) |=> (!parity_err && !frame_err && !overrun)); // R10

endmodule

bind srx_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .char_done     (done_w),
   .char_par_bad  (par_bad_w),
   .char_stop_bad (stop_bad_w),
   .rd_data       (rd_data),
   .rd_status     (rd_status),
   .rx_data       (rx_data),
   .data_ready    (data_ready),
   .parity_err    (parity_err),
   .frame_err     (frame_err),
   .overrun       (overrun)
);

// File: tb/srx_receiver_tb.sv
`timescale 1ns/100ps
module srx_receiver_tb;
   localparam int DATA_W = 8;
   localparam int DIV_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_line = 1'b1;
   logic [DIV_W-1:0]  divisor = 8'd1;
   logic              cfg_parity_en = 1'b0;
   logic              cfg_parity_even = 1'b0;
   logic              cfg_parity_sticky = 1'b0;
   logic              rd_data = 1'b0;
   logic              rd_status = 1'b0;
   logic [DATA_W-1:0] rx_data;
   logic              data_ready, parity_err, frame_err, overrun;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   srx_receiver #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .divisor(divisor),
      .cfg_parity_en(cfg_parity_en), .cfg_parity_even(cfg_parity_even),
      .cfg_parity_sticky(cfg_parity_sticky), .rd_data(rd_data),
      .rd_status(rd_status), .rx_data(rx_data), .data_ready(data_ready),
      .parity_err(parity_err), .frame_err(frame_err), .overrun(overrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clocks);
      rx_line = v;
      repeat (clocks) @(posedge clk);
      #1;
   endtask

   // par_mode: 0 none, else send par_bit
   task automatic send_frame(input logic [7:0] b, input bit with_par,
                             input logic par_bit, input logic stop_bit);
      int bt;
      bt = 16 * int'(divisor);
      hold_line(1'b0, bt);
      for (int i = 0; i < 8; i++) hold_line(b[i], bt);
      if (with_par) hold_line(par_bit, bt);
      hold_line(stop_bit, bt);
      hold_line(1'b1, 4);
   endtask

   task automatic read_both();
      rd_data = 1'b1; rd_status = 1'b1;
      @(posedge clk); #1;
      rd_data = 1'b0; rd_status = 1'b0;
      @(posedge clk); #1;
   endtask

   function automatic logic good_par(input logic [7:0] b);
      if (cfg_parity_sticky) return ~cfg_parity_even;
      if (cfg_parity_even)   return 1'($countones(b) % 2);
      return ~1'($countones(b) % 2);
   endfunction

   task automatic frame_and_check(input logic [7:0] b, input bit flip, input string req);
      logic pb;
      pb = good_par(b) ^ flip;
      send_frame(b, cfg_parity_en, pb, 1'b1);
      check(data_ready === 1'b1, req, data_ready, 1);
      check(rx_data === b, req, rx_data, b);
      check(parity_err === flip, req, parity_err, flip);
      check(frame_err === 1'b0, req, frame_err, 0);
      read_both();
      check(!data_ready && !parity_err, req, {data_ready, parity_err}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check({data_ready, parity_err, frame_err, overrun} === 4'b0, "R1", 
            {data_ready, parity_err, frame_err, overrun}, 0);
      check(rx_data === 8'h00, "R1", rx_data, 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk); #1;

      // R2 all values, parity off, divisor 1
      for (int v = 0; v < 256; v++) frame_and_check(8'(v), 1'b0, "R2");

      // R3 even parity, every value, some with a corrupted parity bit
      cfg_parity_en = 1'b1; cfg_parity_even = 1'b1;
      for (int v = 0; v < 256; v++) frame_and_check(8'(v), (v % 4) == 3, "R3");

      // R4 odd parity at divisor 2 (R11)
      cfg_parity_even = 1'b0; divisor = 8'd2;
      for (int v = 0; v < 256; v += 3) frame_and_check(8'(v), (v % 2) == 1, "R4_R11");

      // R5 sticky parity, both select levels, both bit values
      divisor = 8'd1; cfg_parity_sticky = 1'b1;
      for (int s = 0; s < 2; s++) begin
         cfg_parity_even = s[0];
         for (int v = 0; v < 256; v += 16) begin
            frame_and_check(8'(v), 1'b0, "R5");
            frame_and_check(8'(v + 5), 1'b1, "R5");
         end
      end
      cfg_parity_sticky = 1'b0; cfg_parity_en = 1'b0;

      // R6 start glitch shorter than half a bit
      hold_line(1'b0, 3);
      hold_line(1'b1, 48);
      check(data_ready === 1'b0, "R6", data_ready, 0);
      check({parity_err, frame_err, overrun} === 3'b0, "R6", {parity_err, frame_err, overrun}, 0);
      frame_and_check(8'h5A, 1'b0, "R6");

      // R7 low stop bit; R9 rd_data leaves errors; R10 rd_status clears
      send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
      hold_line(1'b1, 32);
      check(frame_err === 1'b1, "R7", frame_err, 1);
      check(data_ready === 1'b1 && rx_data === 8'hA5, "R7", rx_data, 8'hA5);
      rd_data = 1'b1; @(posedge clk); #1; rd_data = 1'b0; @(posedge clk); #1;
      check(data_ready === 1'b0, "R9", data_ready, 0);
      check(rx_data === 8'hA5, "R9", rx_data, 8'hA5);
      check(frame_err === 1'b1, "R9", frame_err, 1);
      rd_status = 1'b1; @(posedge clk); #1; rd_status = 1'b0; @(posedge clk); #1;
      check(frame_err === 1'b0, "R10", frame_err, 0);

      // R8 overrun with no read between characters
      send_frame(8'h11, 1'b0, 1'b0, 1'b1);
      check(overrun === 1'b0, "R8", overrun, 0);
      send_frame(8'h22, 1'b0, 1'b0, 1'b1);
      check(overrun === 1'b1, "R8", overrun, 1);
      check(rx_data === 8'h22 && data_ready === 1'b1, "R8", rx_data, 8'h22);
      rd_status = 1'b1; @(posedge clk); #1; rd_status = 1'b0; @(posedge clk); #1;
      check(overrun === 1'b0, "R10", overrun, 0);
      check(data_ready === 1'b1, "R10", data_ready, 1);
      read_both();

      // R11 larger divisors
      divisor = 8'd3;
      frame_and_check(8'hC3, 1'b0, "R11");
      divisor = 8'd5;
      frame_and_check(8'h3C, 1'b0, "R11");
      frame_and_check(8'h81, 1'b0, "R11");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule